// File: doc/BRIEF.md
# Programmable-Priority Peripheral Interrupt Router

This block gathers a bank of level-sensitive peripheral interrupt lines and steers each one to one of several general-purpose core priority levels. Software chooses the level of every line through a packed 4-bit routing field, enables or disables each line with a mask bit, and marks lines that may wake the core with a separate wake-enable bit. All of this state is reached through a plain 32-bit register write/read port with a combinational read.

For every level the block drives a registered request and a registered vector. The vector names the lowest-numbered line that is routed to that level and is both raised and unmasked. When the core signals that it is servicing a level that has no such line, the event is spurious and a saturating counter records it.

Top module: `prio_irq_router`

## Requirements
- R1: Routing fields are packed eight per 32-bit word: line n owns bits [(n mod 8)*4+3 : (n mod 8)*4] of routing word n/8. With the default 64 lines, routing words sit at addresses 0..7, and every word reads back what was last written to it.
- R2: A routing value v from 0 to 6 sends the line to level v (level 0 is the lowest). Values 7 to 15 send the line to no level, so it never raises a request or a vector.
- R3: Mask, status and wake-enable banks are 32 bits wide, and line n sits at bit n mod 32 of bank n/32. With 64 lines the mask banks are at addresses 8..9, the status banks at 10..11 and the wake-enable banks at 12..13. A status bank reads the current level of its interrupt inputs.
- R4: A line is active only when its input and its mask bit are both 1. A level's request is the OR of the active lines routed to that level, and it appears one clock edge after the inputs or the mask change.
- R5: At the same edge, each level's vector holds the lowest-numbered active line routed to it, with valid set. When the level has no active line, valid is 0 and the line field is 0.
- R6: Each level whose service input is high at a clock edge while it has no active line adds one to the spurious counter. The counter is read at address 14, and it saturates at 2^CNT_W-1 (255 by default).
- R7: Wake-enable bits are independent of the mask. wake_o goes high one edge after any input is high while its wake-enable bit is set, whether or not the line is masked.
- R8: After reset, all routing fields, mask bits, wake-enable bits, the spurious counter and all outputs are 0.
- R9: Writes to the status banks, to the counter address or to unmapped addresses change nothing, and unmapped addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | NUM_LINES | Peripheral interrupt levels (status) |
| svc_i | input | NUM_LEVELS | Core is servicing this level this cycle |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| level_req_o | output | NUM_LEVELS | Registered request per level |
| vec_valid_o | output | NUM_LEVELS | Registered vector valid per level |
| vec_line_o | output | NUM_LEVELS*LINE_W | Registered winning line number per level |
| wake_o | output | 1 | Registered wake request |

## Verification
The embedded properties check on every cycle that a raised request or wake was backed by an active or wake-enabled input one edge earlier. They also check that any valid vector names a line that was then active, and that the spurious counter never falls and stays at its ceiling once it gets there. Only the bench scenarios show that the lowest line number wins inside a level, that the field and bank positions map correctly, that routing values 7 to 15 are inert, that the counter adds the right amount per spurious level, and that protected addresses ignore writes. The bench checks these with a per-line sweep over every routing value and with pseudo-random multi-line patterns under two routings and a partial mask.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
   localparam int REG_W   = 32;
   localparam int FIELD_W = 4;
   localparam int FIELDS_PER_WORD = REG_W / FIELD_W;

   function automatic int words_for(input int lines, input int per_word);
      return (lines + per_word - 1) / per_word;
   endfunction
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
   import irq_router_pkg::*;
#(
   parameter int NUM_LINES = 64,
   parameter int CNT_W     = 8,
   parameter int ADDR_W    = 4
) (
   input  logic                          clk_i,
   input  logic                          rst_ni,
   input  logic                          wr_i,
   input  logic [ADDR_W-1:0]             addr_i,
   input  logic [REG_W-1:0]              wdata_i,
   input  logic [NUM_LINES-1:0]          status_i,
   input  logic [CNT_W-1:0]              spur_cnt_i,
   output logic [REG_W-1:0]              rdata_o,
   output logic [NUM_LINES*FIELD_W-1:0]  route_o,
   output logic [NUM_LINES-1:0]          mask_o,
   output logic [NUM_LINES-1:0]          wake_en_o
);
   localparam int A_WORDS   = words_for(NUM_LINES, FIELDS_PER_WORD);
   localparam int BANKS     = words_for(NUM_LINES, REG_W);
   localparam int MASK_BASE = A_WORDS;
   localparam int STAT_BASE = MASK_BASE + BANKS;
   localparam int WAKE_BASE = STAT_BASE + BANKS;
   localparam int SPUR_ADDR = WAKE_BASE + BANKS;

   logic [A_WORDS*REG_W-1:0] route_q;
   logic [BANKS*REG_W-1:0]   mask_q;
   logic [BANKS*REG_W-1:0]   wake_q;
   logic [BANKS*REG_W-1:0]   status_ext;

   assign status_ext = (BANKS*REG_W)'(status_i);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         route_q <= '0;
         mask_q  <= '0;
         wake_q  <= '0;
      end else if (wr_i) begin
         for (int w = 0; w < A_WORDS; w++)
            if (addr_i == ADDR_W'(w)) route_q[w*REG_W +: REG_W] <= wdata_i;
         for (int b = 0; b < BANKS; b++) begin
            if (addr_i == ADDR_W'(MASK_BASE + b)) mask_q[b*REG_W +: REG_W] <= wdata_i;
            if (addr_i == ADDR_W'(WAKE_BASE + b)) wake_q[b*REG_W +: REG_W] <= wdata_i;
         end
      end
   end

   always_comb begin
      rdata_o = '0;
      for (int w = 0; w < A_WORDS; w++)
         if (addr_i == ADDR_W'(w)) rdata_o = route_q[w*REG_W +: REG_W];
      for (int b = 0; b < BANKS; b++) begin
         if (addr_i == ADDR_W'(MASK_BASE + b)) rdata_o = mask_q[b*REG_W +: REG_W];
         if (addr_i == ADDR_W'(STAT_BASE + b)) rdata_o = status_ext[b*REG_W +: REG_W];
         if (addr_i == ADDR_W'(WAKE_BASE + b)) rdata_o = wake_q[b*REG_W +: REG_W];
      end
      if (addr_i == ADDR_W'(SPUR_ADDR)) rdata_o = REG_W'(spur_cnt_i);
   end

   assign route_o   = route_q[NUM_LINES*FIELD_W-1:0];
   assign mask_o    = mask_q[NUM_LINES-1:0];
   assign wake_en_o = wake_q[NUM_LINES-1:0];
endmodule

// File: rtl/irq_level_scan.sv
module irq_level_scan
   import irq_router_pkg::*;
#(
   parameter int NUM_LINES = 64,
   parameter int LEVEL     = 0,
   parameter int LINE_W    = 6
) (
   input  logic                          clk_i,
   input  logic                          rst_ni,
   input  logic [NUM_LINES-1:0]          active_i,
   input  logic [NUM_LINES*FIELD_W-1:0]  route_i,
   output logic                          any_o,
   output logic                          req_o,
   output logic                          valid_o,
   output logic [LINE_W-1:0]             line_o
);
   logic [NUM_LINES-1:0] hit;
   logic [LINE_W-1:0]    first_idx;

   always_comb begin
      for (int n = 0; n < NUM_LINES; n++)
         hit[n] = active_i[n] && (route_i[n*FIELD_W +: FIELD_W] == FIELD_W'(LEVEL));
   end

   always_comb begin
      first_idx = '0;
      for (int n = NUM_LINES - 1; n >= 0; n--)
         if (hit[n]) first_idx = LINE_W'(n);
   end

   assign any_o = |hit;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         req_o   <= 1'b0;
         valid_o <= 1'b0;
         line_o  <= '0;
      end else begin
         req_o   <= any_o;
         valid_o <= any_o;
         line_o  <= first_idx;
      end
   end
endmodule

// File: rtl/irq_spur_cnt.sv
module irq_spur_cnt #(
   parameter int NUM_LEVELS = 7,
   parameter int CNT_W      = 8
) (
   input  logic                   clk_i,
   input  logic                   rst_ni,
   input  logic [NUM_LEVELS-1:0]  svc_i,
   input  logic [NUM_LEVELS-1:0]  level_any_i,
   output logic [CNT_W-1:0]       cnt_o
);
   localparam int ADD_W = $clog2(NUM_LEVELS + 1);
   localparam logic [CNT_W:0] CNT_MAX = {1'b0, {CNT_W{1'b1}}};

   logic [ADD_W-1:0] add;
   logic [CNT_W:0]   sum;

   always_comb begin
      add = '0;
      for (int l = 0; l < NUM_LEVELS; l++)
         add = add + ADD_W'(svc_i[l] && !level_any_i[l]);
      sum = {1'b0, cnt_o} + (CNT_W+1)'(add);
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)            cnt_o <= '0;
      else if (sum > CNT_MAX) cnt_o <= {CNT_W{1'b1}};
      else                    cnt_o <= sum[CNT_W-1:0];
   end

   AST_SPUR_SATURATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt_o == {CNT_W{1'b1}}) |=> (cnt_o == {CNT_W{1'b1}})); // R6
   AST_SPUR_NO_DECREASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_o >= $past(cnt_o)); // R6
endmodule

// File: rtl/prio_irq_router.sv
module prio_irq_router
   import irq_router_pkg::*;
#(
   parameter int NUM_LINES  = 64,
   parameter int NUM_LEVELS = 7,
   parameter int CNT_W      = 8,
   localparam int LINE_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
   localparam int ADDR_W    = $clog2(words_for(NUM_LINES, FIELDS_PER_WORD)
                                     + 3 * words_for(NUM_LINES, REG_W) + 1)
) (
   input  logic                          clk_i,
   input  logic                          rst_ni,
   input  logic [NUM_LINES-1:0]          irq_i,
   input  logic [NUM_LEVELS-1:0]         svc_i,
   input  logic                          reg_wr_i,
   input  logic [ADDR_W-1:0]             reg_addr_i,
   input  logic [REG_W-1:0]              reg_wdata_i,
   output logic [REG_W-1:0]              reg_rdata_o,
   output logic [NUM_LEVELS-1:0]         level_req_o,
   output logic [NUM_LEVELS-1:0]         vec_valid_o,
   output logic [NUM_LEVELS*LINE_W-1:0]  vec_line_o,
   output logic                          wake_o
);
   if (NUM_LINES % REG_W != 0) begin : g_bad_lines
      $error("NUM_LINES must be a multiple of 32");
   end
   if (NUM_LEVELS < 1 || NUM_LEVELS > (1 << FIELD_W) - 1) begin : g_bad_levels
      $error("NUM_LEVELS must fit below the largest routing value");
   end
   if (CNT_W < 2 || CNT_W > REG_W) begin : g_bad_cnt
      $error("CNT_W out of range");
   end

   logic [NUM_LINES*FIELD_W-1:0] route;
   logic [NUM_LINES-1:0]         mask;
   logic [NUM_LINES-1:0]         wake_en;
   logic [NUM_LINES-1:0]         active;
   logic [NUM_LEVELS-1:0]        level_any;
   logic [CNT_W-1:0]             spur_cnt;

   irq_cfg_regs #(.NUM_LINES(NUM_LINES), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) regs_i (
      .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(reg_wr_i), .addr_i(reg_addr_i),
      .wdata_i(reg_wdata_i), .status_i(irq_i), .spur_cnt_i(spur_cnt),
      .rdata_o(reg_rdata_o), .route_o(route), .mask_o(mask), .wake_en_o(wake_en)
   );

   assign active = irq_i & mask;

   for (genvar l = 0; l < NUM_LEVELS; l++) begin : g_level
      irq_level_scan #(.NUM_LINES(NUM_LINES), .LEVEL(l), .LINE_W(LINE_W)) scan_i (
         .clk_i(clk_i), .rst_ni(rst_ni), .active_i(active), .route_i(route),
         .any_o(level_any[l]), .req_o(level_req_o[l]), .valid_o(vec_valid_o[l]),
         .line_o(vec_line_o[l*LINE_W +: LINE_W])
      );
   end

   irq_spur_cnt #(.NUM_LEVELS(NUM_LEVELS), .CNT_W(CNT_W)) spur_i (
      .clk_i(clk_i), .rst_ni(rst_ni), .svc_i(svc_i), .level_any_i(level_any),
      .cnt_o(spur_cnt)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) wake_o <= 1'b0;
      else         wake_o <= |(irq_i & wake_en);
   end

   // Checking state: snapshot of active lines for the properties below.
   logic [NUM_LINES-1:0] active_q;
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) active_q <= '0;
      else         active_q <= active;
   end

   AST_REQ_BACKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|level_req_o) |-> (|active_q)); // R4
   AST_WAKE_BACKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wake_o |-> $past(|(irq_i & wake_en))); // R7

   for (genvar l = 0; l < NUM_LEVELS; l++) begin : g_chk
      AST_WINNER_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
         vec_valid_o[l] |-> active_q[vec_line_o[l*LINE_W +: LINE_W]]); // R5
   end
endmodule

// File: tb/prio_irq_router_tb_top.sv
module prio_irq_router_tb_top;
   localparam int NL = 64;
   localparam int NV = 7;
   localparam int LW = 6;
   localparam int AW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NL-1:0] irq = '0;
   logic [NV-1:0] svc = '0;
   logic          wr = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [31:0]   wdata = '0;
   logic [31:0]   rdata;
   logic [NV-1:0] req, vvalid;
   logic [NV*LW-1:0] vline;
   logic          wake;

   int n_tests = 0;
   int n_fail  = 0;
   bit done = 1'b0;

   logic [NL-1:0] m_mask = '0;
   logic [3:0]    m_fld [NL];

   always #5 clk = ~clk;

   prio_irq_router dut_i (
      .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .svc_i(svc), .reg_wr_i(wr),
      .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
      .level_req_o(req), .vec_valid_o(vvalid), .vec_line_o(vline), .wake_o(wake)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr_reg(input int a, input logic [31:0] d);
      @(negedge clk);
      wr = 1'b1; addr = AW'(a); wdata = d;
      @(negedge clk);
      wr = 1'b0;
   endtask

   task automatic rd_reg(input int a, output logic [31:0] d);
      @(negedge clk);
      addr = AW'(a);
      #1 d = rdata;
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic push_routing();
      for (int w = 0; w < 8; w++) begin
         logic [31:0] word = '0;
         for (int k = 0; k < 8; k++) word[k*4 +: 4] = m_fld[w*8 + k];
         wr_reg(w, word);
      end
   endtask

   task automatic push_mask();
      wr_reg(8, m_mask[31:0]);
      wr_reg(9, m_mask[63:32]);
   endtask

   // Reference scan: lowest line whose input, mask and routing select the level.
   task automatic check_levels(input string tag);
      logic [NV-1:0] e_req = '0;
      logic [NV*LW-1:0] e_line = '0;
      for (int l = 0; l < NV; l++)
         for (int n = NL - 1; n >= 0; n--)
            if (irq[n] && m_mask[n] && (m_fld[n] == 4'(l))) begin
               e_req[l] = 1'b1;
               e_line[l*LW +: LW] = LW'(n);
            end
      chk({tag, " R4 req"}, 64'(req), 64'(e_req));
      chk({tag, " R5 valid"}, 64'(vvalid), 64'(e_req));
      chk({tag, " R5 line"}, 64'(vline), 64'(e_line));
   endtask

   initial begin
      logic [31:0] d;
      logic [31:0] c0;
      logic [63:0] lfsr = 64'h9E37_79B9_7F4A_7C15;
      for (int n = 0; n < NL; n++) m_fld[n] = '0;
      repeat (3) @(negedge clk);
      chk("R8 req in reset", 64'(req), 0);
      rst_n = 1'b1;
      step();
      // R8: reset values over the whole map
      for (int a = 0; a < 15; a++) begin
         rd_reg(a, d);
         chk($sformatf("R8 reg %0d after reset", a), 64'(d), 0);
      end
      chk("R8 outputs after reset", {vline, vvalid, req, wake}, 0);

      // R1: routing words read back
      for (int w = 0; w < 8; w++) wr_reg(w, 32'h1234_5670 + 32'(w));
      for (int w = 0; w < 8; w++) begin
         rd_reg(w, d);
         chk("R1 routing readback", 64'(d), 64'(32'h1234_5670 + 32'(w)));
      end

      // R9: protected and unmapped addresses
      irq = 64'hA5A5_0000_0000_5A5A;
      wr_reg(10, 32'hFFFF_FFFF);
      rd_reg(10, d); chk("R9/R3 status low ignores write", 64'(d), 64'h5A5A);
      rd_reg(11, d); chk("R3 status high bank", 64'(d), 64'hA5A5_0000);
      wr_reg(14, 32'h55);
      rd_reg(14, d); chk("R9 counter ignores write", 64'(d), 0);
      wr_reg(15, 32'hFFFF_FFFF);
      rd_reg(15, d); chk("R9 unmapped reads zero", 64'(d), 0);
      irq = '0;

      // R7: wake independent of mask
      m_mask = '0; push_mask();
      wr_reg(13, 32'h0000_0100);             // line 40
      irq[40] = 1'b1; step();
      chk("R7 wake while masked", 64'(wake), 1);
      chk("R7 no request while masked", 64'(req), 0);
      irq[40] = 1'b0; irq[39] = 1'b1; step();
      chk("R7 no wake from disabled line", 64'(wake), 0);
      irq = '0;
      wr_reg(13, 0);

      // R1/R2/R3/R4/R5: single-line sweep, every routing value 0..15 used
      for (int n = 0; n < NL; n++) m_fld[n] = 4'((n * 5) % 16);
      push_routing();
      m_mask = '1; push_mask();
      rd_reg(9, d); chk("R3 mask high bank readback", 64'(d), 64'hFFFF_FFFF);
      for (int n = 0; n < NL; n++) begin
         irq = '0; irq[n] = 1'b1;
         step();
         check_levels($sformatf("R1 R2 sweep line %0d", n));
      end

      // R4/R5: multi-line patterns, two routings, partial mask
      for (int pass = 0; pass < 2; pass++) begin
         if (pass == 1) begin
            for (int n = 0; n < NL; n++) m_fld[n] = 4'((n * 3 + 1) % 8);
            push_routing();
            m_mask = 64'hF0F0_3C3C_FF00_0FF0; push_mask();
         end
         for (int p = 0; p < 40; p++) begin
            lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
            irq = lfsr & {lfsr[31:0], lfsr[63:32]};
            step();
            check_levels($sformatf("R5 pattern %0d pass %0d", p, pass));
         end
      end
      // R4: mask change alone updates request one edge later
      irq = 64'h1; m_fld[0] = 4'd3;
      push_routing();
      m_mask = '0; push_mask(); step();
      check_levels("R4 masked line 0");
      m_mask = 64'h1; push_mask(); step();
      check_levels("R4 unmasked line 0");

      // R6: spurious counting
      rd_reg(14, c0);
      chk("R6 counter clean", 64'(c0), 0);
      @(negedge clk); svc = 7'b000_1000;     // level 3 has line 0 active
      @(negedge clk); svc = '0;
      rd_reg(14, d); chk("R6 serviced level not spurious", 64'(d), 0);
      @(negedge clk); svc = 7'b101_0000;     // levels 4 and 6 empty
      @(negedge clk); svc = '0;
      rd_reg(14, d); chk("R6 two spurious levels", 64'(d), 2);
      @(negedge clk); svc = 7'b100_0000;
      repeat (300) @(negedge clk);
      svc = '0;
      rd_reg(14, d); chk("R6 saturation", 64'(d), 255);
      irq = '0;

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule